// File: doc/BRIEF.md
# Double-Transition Data-In CRC Checker

This block keeps a running 32-bit CRC over the 16-bit words arriving on the data-in path of a double-transition parallel bus. It compares that CRC with a received check word whenever the bus control logic asks, or whenever software fires a test strobe. A mismatch is recorded in a sticky error bit of a control/status byte. That bit is mirrored into an interrupt status line only when both CRC checking and the parity/CRC interrupt are enabled.

Software programs the block through the control/status byte. The byte holds an automatic-reseed enable, three single-shot test strobes (reseed, compare, fold the holding register) and a two-bit selector that picks what a 32-bit data view returns. A second configuration byte holds one bit that turns off the check for a pending CRC request before a bus phase change. The rest of that byte reads as zero.

Top module: `crc_dt_checker`

## Requirements
- R1: After reset the running CRC is 0xFFFFFFFF, the holding and received registers are zero, and csr_rdata, cfg_rdata, istat_crc and no_req_chk are all zero.
- R2: A cycle with din_vld high folds din into the running CRC one bit at a time, MSB first, with polynomial 0x04C11DB7. The result is visible on crc_data the next cycle when the selector is 00. din is also captured into the holding register, which the selector value 01 shows zero-extended.
- R3: A cycle with bus_chk high compares the running CRC as it stood before that edge against rx_crc. rx_crc is latched into the received register, which the selector value 10 shows. A mismatch sets csr_rdata bit 7 at the next edge. A match leaves that bit unchanged.
- R4: csr_rdata bit 7 stays set until a csr_wr with csr_wdata bit 7 high, or an istat_rd pulse, clears it. A write with bit 7 low does not clear it. A mismatch in the same cycle as a clear leaves it set.
- R5: istat_crc is high exactly when bit 7 is set and both chk_en and perr_ie are high. Bit 7 sets on a mismatch whatever chk_en and perr_ie are.
- R6: While csr_rdata bit 5 (auto-seed) is set, every check reloads the seed at the same edge. The comparison still uses the value from before the seed. While bit 5 is clear, a check leaves the running CRC unchanged.
- R7: bus_seed reloads 0xFFFFFFFF at the next edge at any time. A reseed of any origin takes precedence over an accumulate in the same cycle.
- R8: Writing 1 to csr_rdata bit 4 reloads the seed at the edge after the write. Bits 4, 3 and 2 read back as 1 for exactly the one cycle after the write and then read 0.
- R9: Writing 1 to bit 3 compares the running CRC against the received register at the edge after the write, with the same error effect as R3.
- R10: Writing 1 to bit 2 folds the holding register into the running CRC at the edge after the write. If din_vld is high in that cycle, din is folded instead.
- R11: The selector in bits 1:0 picks the crc_data view: 00 running CRC, 01 holding register, 10 received register, 11 the seed 0xFFFFFFFF.
- R12: cfg_wr stores cfg_wdata bit 6. That bit drives no_req_chk and reads back at cfg_rdata bit 6. All other cfg_rdata bits and csr_rdata bit 6 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| din_vld | input | 1 | Data word valid on the data-in path |
| din | input | 16 | Data word from the bus |
| bus_chk | input | 1 | Check request from the bus control logic |
| rx_crc | input | 32 | Received CRC word for a bus check |
| bus_seed | input | 1 | Reseed request from the bus control logic |
| csr_wr | input | 1 | Write strobe for the control/status byte |
| csr_wdata | input | 8 | Write data for the control/status byte |
| cfg_wr | input | 1 | Write strobe for the configuration byte |
| cfg_wdata | input | 8 | Write data for the configuration byte |
| istat_rd | input | 1 | Pulse: software read the interrupt status pair |
| chk_en | input | 1 | CRC checking enabled |
| perr_ie | input | 1 | Parity/CRC interrupt enabled |
| csr_rdata | output | 8 | Control/status byte read value |
| cfg_rdata | output | 8 | Configuration byte read value |
| crc_data | output | 32 | Data view chosen by the selector |
| istat_crc | output | 1 | Error mirror into interrupt status bit 0 |
| no_req_chk | output | 1 | Pre-phase-change CRC request check disabled |

## Verification
The assertions check on every cycle that a mismatch sets the error bit, that the bit holds until a clear, and that a clear without a coincident mismatch resets it. They also check that every reseed lands the seed value, that the test strobes read back for a single cycle, and that the interrupt mirror never rises without the error bit. Only the bench scenarios show the CRC arithmetic itself, the selector views, the use of the pre-seed value when a check and an auto-seed coincide, and the precedence of bus data over the test accumulate. The same holds for the one-cycle delay of each test strobe and the configuration bit. The bench shows these by comparing every output each cycle against a model kept in the bench.

// File: rtl/crc_chk_pkg.sv
package crc_chk_pkg;
  typedef enum logic [1:0] {
    VIEW_RUN  = 2'b00,
    VIEW_HOLD = 2'b01,
    VIEW_RCV  = 2'b10,
    VIEW_SEED = 2'b11
  } view_e;

  localparam int CSR_ERR  = 7;
  localparam int CSR_AUTO = 5;
  localparam int CSR_TSD  = 4;
  localparam int CSR_TCK  = 3;
  localparam int CSR_TAD  = 2;
  localparam int CFG_NRC  = 6;
endpackage

// File: rtl/crc_dt_ctl.sv
module crc_dt_ctl
  import crc_chk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csr_wr,
  input  logic [7:0] csr_wdata,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  output logic       auto_seed,
  output logic       tst_seed,
  output logic       tst_chk,
  output logic       tst_add,
  output view_e      view,
  output logic       no_req_chk,
  output logic       w1c_err
);
  // Strobes live for the single cycle after the write, then drop.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_seed  <= 1'b0;
      tst_seed   <= 1'b0;
      tst_chk    <= 1'b0;
      tst_add    <= 1'b0;
      view       <= VIEW_RUN;
      no_req_chk <= 1'b0;
    end else begin
      tst_seed <= csr_wr & csr_wdata[CSR_TSD];
      tst_chk  <= csr_wr & csr_wdata[CSR_TCK];
      tst_add  <= csr_wr & csr_wdata[CSR_TAD];
      if (csr_wr) begin
        auto_seed <= csr_wdata[CSR_AUTO];
        view      <= view_e'(csr_wdata[1:0]);
      end
      if (cfg_wr) no_req_chk <= cfg_wdata[CFG_NRC];
    end
  end

  assign w1c_err = csr_wr & csr_wdata[CSR_ERR];
endmodule

// File: rtl/crc_dt_accum.sv
module crc_dt_accum #(
  parameter int              CRC_W  = 32,
  parameter int              DATA_W = 16,
  parameter logic [CRC_W-1:0] POLY  = 32'h04C11DB7,
  parameter logic [CRC_W-1:0] SEED  = 32'hFFFFFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din_vld,
  input  logic [DATA_W-1:0] din,
  input  logic              tst_add,
  input  logic              seed_evt,
  output logic              acc_evt,
  output logic [DATA_W-1:0] hold_q,
  output logic [CRC_W-1:0]  crc_q
);
  // Serial MSB-first division of one data word into the running remainder.
  function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] c,
                                                input logic [DATA_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = c;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ d[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ POLY;
    end
    return r;
  endfunction

  logic [DATA_W-1:0] acc_word;

  assign acc_evt  = din_vld | tst_add;
  assign acc_word = din_vld ? din : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= SEED;
      hold_q <= '0;
    end else begin
      if (seed_evt)     crc_q <= SEED;
      else if (acc_evt) crc_q <= crc_fold(crc_q, acc_word);
      if (din_vld) hold_q <= din;
    end
  end
endmodule

// File: rtl/crc_dt_cmp.sv
module crc_dt_cmp #(
  parameter int CRC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_chk,
  input  logic [CRC_W-1:0] rx_crc,
  input  logic             tst_chk,
  input  logic [CRC_W-1:0] crc_q,
  input  logic             err_clr,
  output logic             chk_evt,
  output logic             mismatch,
  output logic [CRC_W-1:0] rcv_q,
  output logic             err_q
);
  logic [CRC_W-1:0] ref_word;

  assign chk_evt  = bus_chk | tst_chk;
  assign ref_word = bus_chk ? rx_crc : rcv_q;
  assign mismatch = chk_evt && (crc_q != ref_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcv_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (bus_chk) rcv_q <= rx_crc;
      if (mismatch)     err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end
endmodule

// File: rtl/crc_dt_checker.sv
module crc_dt_checker
  import crc_chk_pkg::*;
#(
  parameter int               CRC_W  = 32,
  parameter int               DATA_W = 16,
  parameter logic [CRC_W-1:0] POLY   = 32'h04C11DB7,
  parameter logic [CRC_W-1:0] SEED   = 32'hFFFFFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din_vld,
  input  logic [DATA_W-1:0] din,
  input  logic              bus_chk,
  input  logic [CRC_W-1:0]  rx_crc,
  input  logic              bus_seed,
  input  logic              csr_wr,
  input  logic [7:0]        csr_wdata,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_wdata,
  input  logic              istat_rd,
  input  logic              chk_en,
  input  logic              perr_ie,
  output logic [7:0]        csr_rdata,
  output logic [7:0]        cfg_rdata,
  output logic [CRC_W-1:0]  crc_data,
  output logic              istat_crc,
  output logic              no_req_chk
);
  logic              auto_seed, tst_seed, tst_chk, tst_add, w1c_err;
  view_e             view;
  logic              chk_evt, mismatch, seed_evt, acc_evt, err_clr, err_q;
  logic [CRC_W-1:0]  crc_q, rcv_q;
  logic [DATA_W-1:0] hold_q;

  crc_dt_ctl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .auto_seed(auto_seed), .tst_seed(tst_seed), .tst_chk(tst_chk),
    .tst_add(tst_add), .view(view), .no_req_chk(no_req_chk),
    .w1c_err(w1c_err)
  );

  assign seed_evt = bus_seed | tst_seed | (auto_seed & chk_evt);
  assign err_clr  = istat_rd | w1c_err;

  crc_dt_accum #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY), .SEED(SEED)) u_acc (
    .clk(clk), .rst_n(rst_n),
    .din_vld(din_vld), .din(din), .tst_add(tst_add),
    .seed_evt(seed_evt), .acc_evt(acc_evt),
    .hold_q(hold_q), .crc_q(crc_q)
  );

  crc_dt_cmp #(.CRC_W(CRC_W)) u_cmp (
    .clk(clk), .rst_n(rst_n),
    .bus_chk(bus_chk), .rx_crc(rx_crc), .tst_chk(tst_chk),
    .crc_q(crc_q), .err_clr(err_clr),
    .chk_evt(chk_evt), .mismatch(mismatch),
    .rcv_q(rcv_q), .err_q(err_q)
  );

  always_comb begin
    case (view)
      VIEW_RUN:  crc_data = crc_q;
      VIEW_HOLD: crc_data = CRC_W'(hold_q);
      VIEW_RCV:  crc_data = rcv_q;
      default:   crc_data = SEED;
    endcase
  end

  assign csr_rdata = {err_q, 1'b0, auto_seed, tst_seed, tst_chk, tst_add, view};
  assign cfg_rdata = {1'b0, no_req_chk, 6'b0};
  assign istat_crc = err_q & chk_en & perr_ie;
endmodule

// File: rtl/crc_dt_checker_sva.sv
module crc_dt_checker_sva #(
  parameter int               CRC_W = 32,
  parameter logic [CRC_W-1:0] SEED  = 32'hFFFFFFFF
) (
  input logic             clk,
  input logic             rst_n,
  input logic             csr_wr,
  input logic [7:0]       csr_rdata,
  input logic             istat_crc,
  input logic             chk_evt,
  input logic             mismatch,
  input logic             seed_evt,
  input logic             err_clr,
  input logic [CRC_W-1:0] crc_q
);
  AST_ERR_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_evt && mismatch) |=> csr_rdata[7]); // R3
  AST_NO_PHANTOM_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_rdata[7] && !(chk_evt && mismatch)) |=> !csr_rdata[7]); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata[7] && !err_clr) |=> csr_rdata[7]); // R4
  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !(chk_evt && mismatch)) |=> !csr_rdata[7]); // R4
  AST_MIRROR_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    istat_crc |-> csr_rdata[7]); // R5
  AST_SEED_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    seed_evt |=> (crc_q == SEED)); // R7
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((|csr_rdata[4:2]) && !csr_wr) |=> (csr_rdata[4:2] == 3'b000)); // R8
endmodule

bind crc_dt_checker crc_dt_checker_sva #(.CRC_W(CRC_W), .SEED(SEED)) u_sva (
  .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_rdata(csr_rdata),
  .istat_crc(istat_crc), .chk_evt(chk_evt), .mismatch(mismatch),
  .seed_evt(seed_evt), .err_clr(err_clr), .crc_q(crc_q)
);

// File: tb/crc_dt_checker_test.sv
module crc_dt_checker_test;
  localparam logic [31:0] P_POLY = 32'h04C11DB7;
  localparam logic [31:0] P_SEED = 32'hFFFFFFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        din_vld = 0, bus_chk = 0, bus_seed = 0, csr_wr = 0, cfg_wr = 0;
  logic        istat_rd = 0, chk_en = 0, perr_ie = 0;
  logic [15:0] din = '0;
  logic [31:0] rx_crc = '0;
  logic [7:0]  csr_wdata = '0, cfg_wdata = '0;
  logic [7:0]  csr_rdata, cfg_rdata;
  logic [31:0] crc_data;
  logic        istat_crc, no_req_chk;

  int checks = 0, errors = 0;
  bit finished = 0;

  // model state
  logic [31:0] m_crc = P_SEED, m_rcv = '0;
  logic [15:0] m_hold = '0;
  logic        m_err = 0, m_auto = 0, m_nrc = 0;
  logic [1:0]  m_sel = 0;
  logic [2:0]  m_tst = 0; // {seed, chk, add}

  always #2 clk = ~clk;

  crc_dt_checker uut (
    .clk(clk), .rst_n(rst_n), .din_vld(din_vld), .din(din), .bus_chk(bus_chk),
    .rx_crc(rx_crc), .bus_seed(bus_seed), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .istat_rd(istat_rd), .chk_en(chk_en),
    .perr_ie(perr_ie), .csr_rdata(csr_rdata), .cfg_rdata(cfg_rdata),
    .crc_data(crc_data), .istat_crc(istat_crc), .no_req_chk(no_req_chk)
  );

  // Word is XORed into the top half, then the register is shifted 16 times.
  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [15:0] w);
    logic [31:0] r = c ^ {w, 16'h0000};
    for (int k = 0; k < 16; k++) r = r[31] ? ((r << 1) ^ P_POLY) : (r << 1);
    return r;
  endfunction

  function automatic logic [31:0] ref_view();
    case (m_sel)
      2'd0: return m_crc;
      2'd1: return {16'h0, m_hold};
      2'd2: return m_rcv;
      default: return P_SEED;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_in();
    din_vld = 0; bus_chk = 0; bus_seed = 0; csr_wr = 0; cfg_wr = 0; istat_rd = 0;
  endtask

  // One clock: advance the model with the driven inputs, then compare outputs.
  task automatic cyc();
    logic        c_chk, c_mis, c_seed, c_acc, c_clr;
    logic [15:0] w;
    c_chk  = bus_chk | m_tst[1];
    c_mis  = c_chk && (m_crc != (bus_chk ? rx_crc : m_rcv));
    c_seed = bus_seed | m_tst[2] | (m_auto & c_chk);
    c_acc  = din_vld | m_tst[0];
    w      = din_vld ? din : m_hold;
    c_clr  = istat_rd | (csr_wr & csr_wdata[7]);
    @(posedge clk);
    #1;
    if (c_seed) m_crc = P_SEED;
    else if (c_acc) m_crc = ref_crc(m_crc, w);
    if (din_vld) m_hold = din;
    if (bus_chk) m_rcv = rx_crc;
    if (c_mis) m_err = 1;
    else if (c_clr) m_err = 0;
    m_tst = csr_wr ? csr_wdata[4:2] : 3'b000;
    if (csr_wr) begin m_auto = csr_wdata[5]; m_sel = csr_wdata[1:0]; end
    if (cfg_wr) m_nrc = cfg_wdata[6];
    case (m_sel)
      2'd0: chk("R2 running view", crc_data, ref_view());
      2'd1: chk("R2 holding view", crc_data, ref_view());
      2'd2: chk("R3 received view", crc_data, ref_view());
      default: chk("R11 seed view", crc_data, ref_view());
    endcase
    chk("R4 error bit", {31'h0, csr_rdata[7]}, {31'h0, m_err});
    chk("R8 strobe readback", {29'h0, csr_rdata[4:2]}, {29'h0, m_tst});
    chk("R6 auto bit", {31'h0, csr_rdata[5]}, {31'h0, m_auto});
    chk("R5 mirror", {31'h0, istat_crc}, {31'h0, m_err & chk_en & perr_ie});
    chk("R12 config", {24'h0, cfg_rdata}, {24'h0, 1'b0, m_nrc, 6'h0});
  endtask

  task automatic wr_csr(input logic [7:0] v);
    csr_wr = 1; csr_wdata = v; cyc(); idle_in();
  endtask

  task automatic push(input logic [15:0] v);
    din_vld = 1; din = v; cyc(); idle_in();
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] pre;
    void'($urandom(32'h5EED1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1 crc_data", crc_data, P_SEED);
    chk("R1 csr_rdata", {24'h0, csr_rdata}, 32'h0);
    chk("R1 cfg_rdata", {24'h0, cfg_rdata}, 32'h0);
    chk("R1 istat/no_req", {30'h0, istat_crc, no_req_chk}, 32'h0);

    // R2 accumulate and holding view
    push(16'h1234); push(16'hABCD); push(16'h0000);
    wr_csr(8'h01);
    chk("R2 hold captured", crc_data, 32'h0000_0000);
    wr_csr(8'h00);

    // R6 auto-seed: matching check uses the pre-seed value, then reseeds
    wr_csr(8'h20);
    push(16'hBEEF);
    bus_chk = 1; rx_crc = m_crc; cyc(); idle_in();
    chk("R6 reseed after check", crc_data, P_SEED);
    chk("R6 no error on match", {31'h0, csr_rdata[7]}, 32'h0);

    // R7 bus seed beats accumulate
    push(16'h5A5A);
    bus_seed = 1; din_vld = 1; din = 16'h1111; cyc(); idle_in();
    chk("R7 seed over accumulate", crc_data, P_SEED);

    // R10 test accumulate folds holding register one cycle after write
    wr_csr(8'h00);
    push(16'hC0DE);
    pre = m_crc;
    wr_csr(8'h04);
    chk("R10 not yet folded", crc_data, pre);
    cyc();
    chk("R10 folded holding", crc_data, ref_crc(pre, 16'hC0DE));

    // R9 test check against stored received word, mismatch sets error
    chk_en = 1; perr_ie = 0;
    wr_csr(8'h08);
    cyc();
    chk("R9 test check error", {31'h0, csr_rdata[7]}, 32'h1);
    chk("R5 mirror gated off", {31'h0, istat_crc}, 32'h0);
    perr_ie = 1; cyc();
    chk("R5 mirror on", {31'h0, istat_crc}, 32'h1);

    // R4 write zero keeps, W1C clears, istat_rd clears, mismatch beats clear
    wr_csr(8'h00);
    chk("R4 zero write keeps", {31'h0, csr_rdata[7]}, 32'h1);
    wr_csr(8'h80);
    chk("R4 w1c clears", {31'h0, csr_rdata[7]}, 32'h0);
    bus_chk = 1; rx_crc = ~m_crc; cyc(); idle_in();
    chk("R3 bus mismatch", {31'h0, csr_rdata[7]}, 32'h1);
    istat_rd = 1; cyc(); idle_in();
    chk("R4 istat_rd clears", {31'h0, csr_rdata[7]}, 32'h0);
    istat_rd = 1; bus_chk = 1; rx_crc = ~m_crc; cyc(); idle_in();
    chk("R4 mismatch beats clear", {31'h0, csr_rdata[7]}, 32'h1);

    // R8 test seed
    push(16'h7777);
    wr_csr(8'h10);
    chk("R8 strobe visible", {29'h0, csr_rdata[4:2]}, 32'h4);
    cyc();
    chk("R8 reseeded", crc_data, P_SEED);
    chk("R8 strobe cleared", {29'h0, csr_rdata[4:2]}, 32'h0);

    // R11 seed view, R12 config bit
    wr_csr(8'h83);
    chk("R11 seed view", crc_data, P_SEED);
    cfg_wr = 1; cfg_wdata = 8'hFF; cyc(); idle_in();
    chk("R12 no_req_chk set", {31'h0, no_req_chk}, 32'h1);
    chk("R12 readback", {24'h0, cfg_rdata}, 32'h40);

    // Constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      din_vld  = ($urandom % 10) < 4;
      din      = 16'($urandom);
      bus_chk  = ($urandom % 10) == 0;
      rx_crc   = ($urandom % 2) ? m_crc : $urandom;
      bus_seed = ($urandom % 20) == 0;
      istat_rd = ($urandom % 25) == 0;
      csr_wr   = ($urandom % 12) == 0;
      csr_wdata = 8'($urandom);
      cfg_wr   = ($urandom % 40) == 0;
      cfg_wdata = 8'($urandom);
      chk_en   = 1'($urandom);
      perr_ie  = 1'($urandom);
      cyc();
    end
    idle_in();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule